// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block watches a wide bank of general-purpose input pins and folds them into one interrupt request line. It does not give every pin its own interrupt. It offers a fixed number of interrupt slots (eight by default). Each slot picks one pin out of a small lane of candidates and applies its own trigger rule to it. Each slot has a pending flag, an enable bit and a write-one-to-clear acknowledge.

Every pin is passed through a two-stage synchroniser, and one more delayed copy is kept for edge detection. Each slot can run in one of three kinds of mode. Level modes follow the chosen pin. Edge modes latch an event until software acknowledges it. Constant modes force the flag on or off. Software reaches the block through a small word-wide register port, and the single interrupt output is registered.

Top module: `pin_irq_hub`

## Requirements
- R1: After reset, the trigger, routing and enable registers read zero, every pending flag is clear and `irq_o` is low.
- R2: Register words, by byte address: trigger modes 0x00 (slot g at bits 3g+2:3g), routing 0x04 (slot g at bits 4g+3:4g), enable 0x08 (bit g), acknowledge 0x0C (write-only, reads zero), raw pending 0x10 (read-only), enabled pending 0x14 (read-only). Read data appears on `rdata_o` one cycle after the read request. Unused high bits read zero.
- R3: Slot g with routing value s watches bit `{s, g}` of `pins_i`, which is bit 32*s[3:2] + 8*s[1:0] + g. No other pin affects it.
- R4: Trigger code 1 (level high) makes the raw flag equal to the synchronised level of the chosen pin.
- R5: Trigger code 2 (level low) makes the raw flag equal to the inverse of the synchronised level of the chosen pin.
- R6: Trigger code 3 holds the raw flag set, whatever the pin does.
- R7: Trigger codes 0 and 4 hold the raw flag clear, whatever the pin does.
- R8: Trigger codes 5 (rising), 6 (falling) and 7 (either edge) set the flag on the matching transition of the synchronised pin. The flag stays set after the pin returns to its old level, until it is acknowledged. A transition in the other direction does not set the flag in codes 5 and 6.
- R9: Writing the acknowledge word clears the edge-latched flag of each slot whose bit is 1. Slots whose bit is 0 keep their flag. In level and forced modes the flag comes straight back while the condition holds.
- R10: If a matching edge and an acknowledge of the same slot land in the same cycle, the flag stays set.
- R11: The enabled-pending word equals raw pending AND enable. `irq_o` is the OR of its bits, registered, so it follows one cycle later.
- R12: Reads of unused addresses return zero. Writes to unused addresses or to the read-only words change no register.
- R13: In a level mode with the slot enabled, a pin change driven between clock edges shows on `irq_o` at the fourth rising edge after the change, and not at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pins_i | input | 128 | Asynchronous input pins, flattened as {lane group, slot} |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
A vector table drives level, forced and disabled slots on scattered routing values. Each vector is tried twice: once with only the target pin active, and once with every pin except the target driven to the opposite level. This tells correct routing apart from a neighbouring pin or an OR over the lane. Directed sequences then drive rising, falling and either-edge events, including a reversed transition, to separate latching from level following. An acknowledge is timed into the exact cycle a new edge is seen, and another is written with zero bits, to separate edge-wins from ack-wins and selective clearing from blanket clearing. The interrupt output is timed edge by edge after a pin change, to pin down the synchroniser and output register depth.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int unsigned TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSV  = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_mode_e;

  // byte offsets of the register words
  localparam int unsigned OFS_TRIG  = 'h00;
  localparam int unsigned OFS_ROUTE = 'h04;
  localparam int unsigned OFS_ENA   = 'h08;
  localparam int unsigned OFS_ACK   = 'h0C;
  localparam int unsigned OFS_RAW   = 'h10;
  localparam int unsigned OFS_PEND  = 'h14;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  // two flops for metastability, one more for the edge reference
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/pin_irq_slot.sv
module pin_irq_slot
  import pin_irq_pkg::*;
#(
  parameter int unsigned NGRP    = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned GRP_IDX = 0
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [(2**(SEL_W+((NGRP>1)?$clog2(NGRP):1)))-1:0] cur_i,
  input  logic [(2**(SEL_W+((NGRP>1)?$clog2(NGRP):1)))-1:0] prev_i,
  input  logic [TRIG_W-1:0]               mode_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic                            ack_i,
  output logic                            pend_o
);

  localparam int unsigned GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int unsigned IDX_W = SEL_W + GRP_W;
  localparam logic [GRP_W-1:0] GRP_C = GRP_W'(GRP_IDX);

  logic [IDX_W-1:0] idx;
  logic             cur_bit;
  logic             prev_bit;
  logic             edge_hit;
  logic             is_edge;
  logic             pend_q;
  trig_mode_e       mode;

  // the slot number fills the low index bits, the routing value the rest
  assign idx      = {sel_i, GRP_C};
  assign cur_bit  = cur_i[idx];
  assign prev_bit = prev_i[idx];
  assign mode     = trig_mode_e'(mode_i);

  always_comb begin
    edge_hit = 1'b0;
    is_edge  = 1'b0;
    case (mode)
      TRIG_RISE: begin is_edge = 1'b1; edge_hit = cur_bit & ~prev_bit; end
      TRIG_FALL: begin is_edge = 1'b1; edge_hit = ~cur_bit & prev_bit; end
      TRIG_ANY:  begin is_edge = 1'b1; edge_hit = cur_bit ^ prev_bit;  end
      default:   begin is_edge = 1'b0; edge_hit = 1'b0;                end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
    end else begin
      case (mode)
        TRIG_HIGH: pend_q <= cur_bit;
        TRIG_LOW:  pend_q <= ~cur_bit;
        TRIG_SET:  pend_q <= 1'b1;
        TRIG_RISE, TRIG_FALL, TRIG_ANY:
                   pend_q <= edge_hit | (pend_q & ~ack_i);
        default:   pend_q <= 1'b0;
      endcase
    end
  end

  assign pend_o = pend_q;

  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == TRIG_OFF || mode == TRIG_RSV) |=> !pend_q); // R7
  AST_SET_FORCE: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == TRIG_SET) |=> pend_q); // R6
  AST_LEVEL_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == TRIG_HIGH) |=> (pend_q == $past(cur_bit))); // R4
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_edge && pend_q && !ack_i) |=> pend_q); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_edge && ack_i && !edge_hit) |=> !pend_q); // R9
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_hit |=> pend_q); // R10

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic [NGRP-1:0]        raw_i,
  output logic [NGRP*TRIG_W-1:0] trig_o,
  output logic [NGRP*SEL_W-1:0]  route_o,
  output logic [NGRP-1:0]        ack_o,
  output logic [NGRP-1:0]        pend_o
);

  localparam int unsigned CFG_W = NGRP * TRIG_W;
  localparam int unsigned RTE_W = NGRP * SEL_W;
  localparam int unsigned WA_W  = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_TRIG  = WA_W'(OFS_TRIG  >> 2);
  localparam logic [WA_W-1:0] W_ROUTE = WA_W'(OFS_ROUTE >> 2);
  localparam logic [WA_W-1:0] W_ENA   = WA_W'(OFS_ENA   >> 2);
  localparam logic [WA_W-1:0] W_ACK   = WA_W'(OFS_ACK   >> 2);
  localparam logic [WA_W-1:0] W_RAW   = WA_W'(OFS_RAW   >> 2);
  localparam logic [WA_W-1:0] W_PEND  = WA_W'(OFS_PEND  >> 2);

  logic [WA_W-1:0]   word;
  logic              wr;
  logic              rd;
  logic              hit_any;
  logic [CFG_W-1:0]  trig_q;
  logic [RTE_W-1:0]  route_q;
  logic [NGRP-1:0]   ena_q;
  logic [NGRP-1:0]   pend_vec;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  assign word     = addr_i[ADDR_W-1:2];
  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign pend_vec = raw_i & ena_q;
  assign hit_any  = (word == W_TRIG) || (word == W_ROUTE) || (word == W_ENA) ||
                    (word == W_ACK)  || (word == W_RAW)   || (word == W_PEND);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      trig_q  <= '0;
      route_q <= '0;
      ena_q   <= '0;
    end else if (wr) begin
      case (word)
        W_TRIG:  trig_q  <= wdata_i[CFG_W-1:0];
        W_ROUTE: route_q <= wdata_i[RTE_W-1:0];
        W_ENA:   ena_q   <= wdata_i[NGRP-1:0];
        default: ;
      endcase
    end
  end

  // one-cycle clear pulse, taken straight from the bus
  assign ack_o = (wr && word == W_ACK) ? wdata_i[NGRP-1:0] : '0;

  always_comb begin
    case (word)
      W_TRIG:  rd_val = DATA_W'(trig_q);
      W_ROUTE: rd_val = DATA_W'(route_q);
      W_ENA:   rd_val = DATA_W'(ena_q);
      W_RAW:   rd_val = DATA_W'(raw_i);
      W_PEND:  rd_val = DATA_W'(pend_vec);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd ? rd_val : '0;
  end

  assign rdata_o = rdata_q;
  assign trig_o  = trig_q;
  assign route_o = route_q;
  assign pend_o  = pend_vec;

  AST_RST_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> (trig_q == '0 && route_q == '0 && ena_q == '0)); // R1
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd && !hit_any) |=> (rdata_o == '0)); // R12
  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr |=> ($stable(trig_q) && $stable(route_q) && $stable(ena_q))); // R12

endmodule

// File: rtl/pin_irq_hub.sv
module pin_irq_hub
  import pin_irq_pkg::*;
#(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [(2**(SEL_W+((NGRP>1)?$clog2(NGRP):1)))-1:0] pins_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);

  localparam int unsigned GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int unsigned NPIN  = 2 ** (SEL_W + GRP_W);

  logic [NPIN-1:0]          cur;
  logic [NPIN-1:0]          prev;
  logic [NGRP*TRIG_W-1:0]   trig;
  logic [NGRP*SEL_W-1:0]    route;
  logic [NGRP-1:0]          ack;
  logic [NGRP-1:0]          raw;
  logic [NGRP-1:0]          pend_vec;
  logic                     irq_q;

  pin_irq_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pins_i (pins_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  pin_irq_regs #(
    .NGRP(NGRP), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .raw_i   (raw),
    .trig_o  (trig),
    .route_o (route),
    .ack_o   (ack),
    .pend_o  (pend_vec)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_slot
    pin_irq_slot #(.NGRP(NGRP), .SEL_W(SEL_W), .GRP_IDX(g)) u_slot (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .cur_i  (cur),
      .prev_i (prev),
      .mode_i (trig[g*TRIG_W +: TRIG_W]),
      .sel_i  (route[g*SEL_W +: SEL_W]),
      .ack_i  (ack[g]),
      .pend_o (raw[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |pend_vec;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_o) |-> $past(pend_vec != '0)); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_vec == '0) |=> !irq_o); // R11

endmodule

// File: tb/pin_irq_hub_bench.sv
module pin_irq_hub_bench;

  localparam int unsigned CLK_P = 10;
  localparam int unsigned NPIN  = 128;
  localparam logic [4:0] A_TRIG = 5'h00, A_ROUTE = 5'h04, A_ENA = 5'h08,
                         A_ACK = 5'h0C, A_RAW = 5'h10, A_PEND = 5'h14;
  // {slot[12:10], mode[9:7], route[6:3], level[2], decoy[1], expected[0]}
  localparam int NVEC = 12;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 3'd1, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'd0, 3'd1, 4'h0, 1'b0, 1'b1, 1'b0},
    {3'd3, 3'd1, 4'h5, 1'b1, 1'b0, 1'b1},
    {3'd3, 3'd1, 4'h5, 1'b0, 1'b1, 1'b0},
    {3'd7, 3'd2, 4'hF, 1'b0, 1'b1, 1'b1},
    {3'd7, 3'd2, 4'hF, 1'b1, 1'b0, 1'b0},
    {3'd5, 3'd2, 4'hA, 1'b0, 1'b1, 1'b1},
    {3'd2, 3'd3, 4'h9, 1'b0, 1'b0, 1'b1},
    {3'd6, 3'd0, 4'h3, 1'b1, 1'b0, 1'b0},
    {3'd6, 3'd4, 4'h3, 1'b1, 1'b0, 1'b0},
    {3'd1, 3'd1, 4'hC, 1'b1, 1'b0, 1'b1},
    {3'd4, 3'd2, 4'h6, 1'b1, 1'b1, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIN-1:0] pins = '0;
  logic            req = 1'b0;
  logic            we = 1'b0;
  logic [4:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;
  int              checks = 0;
  int              fails = 0;
  logic [31:0]     rv;
  logic [2:0]      vg;
  logic [2:0]      vm;
  logic [3:0]      vs;
  logic [6:0]      vidx;

  always #(CLK_P/2) clk = ~clk;

  pin_irq_hub u_pin_irq_hub (
    .clk_i(clk), .rst_i(rst), .pins_i(pins), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk); pins[i] = v;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    bus_rd(A_TRIG, rv);  check("R1 trig", rv, 0);
    bus_rd(A_ROUTE, rv); check("R1 route", rv, 0);
    bus_rd(A_ENA, rv);   check("R1 enable", rv, 0);
    bus_rd(A_RAW, rv);   check("R1 raw", rv, 0);
    bus_rd(A_PEND, rv);  check("R1 pend", rv, 0);

    // R2 register widths
    bus_wr(A_TRIG, 32'hFFFF_FFFF);  bus_rd(A_TRIG, rv);  check("R2 trig width", rv, 32'h00FF_FFFF);
    bus_wr(A_ROUTE, 32'hA5C3_5A3C); bus_rd(A_ROUTE, rv); check("R2 route", rv, 32'hA5C3_5A3C);
    bus_wr(A_ENA, 32'hFFFF_FFFF);   bus_rd(A_ENA, rv);   check("R2 enable width", rv, 32'h0000_00FF);
    bus_rd(A_ACK, rv); check("R2 ack reads zero", rv, 0);
    bus_wr(A_TRIG, 0); bus_wr(A_ROUTE, 0); bus_wr(A_ENA, 0);

    // vector walk: R3 routing, R4, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      vg = VEC[i][12:10]; vm = VEC[i][9:7]; vs = VEC[i][6:3];
      vidx = {vs, vg};
      bus_wr(A_TRIG, 32'(vm) << (3 * int'(vg)));
      bus_wr(A_ROUTE, 32'(vs) << (4 * int'(vg)));
      @(negedge clk);
      pins = VEC[i][1] ? '1 : '0;
      pins[vidx] = VEC[i][2];
      idle(4);
      bus_rd(A_RAW, rv);
      check($sformatf("R3 R4 R5 R6 R7 vector %0d", i), rv, 32'(VEC[i][0]) << vg);
    end
    bus_wr(A_TRIG, 0); bus_wr(A_ROUTE, 0);
    @(negedge clk); pins = '0;
    idle(4);

    // R12 unused and read-only words
    bus_wr(5'h18, 32'hFFFF_FFFF); bus_rd(5'h18, rv); check("R12 unused read", rv, 0);
    bus_rd(5'h1C, rv); check("R12 unused read hi", rv, 0);
    bus_wr(A_TRIG, 32'h3 << 6);
    bus_wr(A_RAW, 0); bus_wr(A_PEND, 0);
    bus_rd(A_RAW, rv); check("R12 raw write ignored", rv, 32'h04);
    bus_rd(A_TRIG, rv); check("R12 trig unchanged", rv, 32'h3 << 6);

    // R11 enable and combined output (slot 2 forced)
    bus_rd(A_PEND, rv); check("R11 pend masked off", rv, 0);
    check("R11 irq off", {31'd0, irq}, 0);
    bus_wr(A_ENA, 32'h04); idle(2);
    bus_rd(A_PEND, rv); check("R11 pend on", rv, 32'h04);
    check("R11 irq on", {31'd0, irq}, 1);
    bus_wr(A_ENA, 32'hFB); idle(2);
    check("R11 irq other bits", {31'd0, irq}, 0);
    bus_wr(A_ENA, 0); bus_wr(A_TRIG, 0);

    // R8 rising
    bus_wr(A_TRIG, 5);
    set_pin(0, 1'b1); bus_rd(A_RAW, rv); check("R8 rise sets", rv, 1);
    set_pin(0, 1'b0); bus_rd(A_RAW, rv); check("R8 rise latched", rv, 1);
    bus_wr(A_ACK, 1); bus_rd(A_RAW, rv); check("R9 ack clears", rv, 0);
    // R8 falling
    bus_wr(A_TRIG, 6);
    set_pin(0, 1'b1); bus_rd(A_RAW, rv); check("R8 fall ignores rise", rv, 0);
    set_pin(0, 1'b0); bus_rd(A_RAW, rv); check("R8 fall sets", rv, 1);
    bus_wr(A_ACK, 1);
    // R8 either edge
    bus_wr(A_TRIG, 7);
    set_pin(0, 1'b1); bus_rd(A_RAW, rv); check("R8 any rise", rv, 1);
    bus_wr(A_ACK, 1);
    set_pin(0, 1'b0); bus_rd(A_RAW, rv); check("R8 any fall", rv, 1);
    // R9 zero bits leave the flag
    bus_wr(A_ACK, 32'hFE); bus_rd(A_RAW, rv); check("R9 zero bits no effect", rv, 1);
    bus_wr(A_ACK, 1);

    // R9 level mode re-asserts
    bus_wr(A_TRIG, 1);
    set_pin(0, 1'b1);
    bus_wr(A_ACK, 1); bus_rd(A_RAW, rv); check("R9 level stays", rv, 1);

    // R10 edge and ack in the same cycle
    bus_wr(A_TRIG, 7);
    @(negedge clk); pins[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_ACK; wdata = 1;
    @(negedge clk); req = 1'b0; we = 1'b0;
    bus_rd(A_RAW, rv); check("R10 edge wins", rv, 1);
    bus_wr(A_ACK, 1); bus_rd(A_RAW, rv); check("R10 plain ack clears", rv, 0);

    // R13 latency to irq_o (slot 1, level high, pin 1)
    bus_wr(A_TRIG, 1 << 3); bus_wr(A_ENA, 2); idle(5);
    check("R13 idle", {31'd0, irq}, 0);
    @(negedge clk); pins[1] = 1'b1;
    idle(3); check("R13 not after 3 edges", {31'd0, irq}, 0);
    idle(1); check("R13 after 4 edges", {31'd0, irq}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule